// File: doc/BRIEF.md
# Shared-Adder Selection Datapath

This is a combinational arithmetic unit that forms each of several sums with one adder. The candidate sums never need to exist at the same time, so the block steers the right pair of operands into the adder and does not build one adder per expression. Operand multiplexers feed the adder, and an output steering stage places the single sum on the result port the current function calls for.

In single-result mode a 2-bit select code picks which sum appears on `r_o`. In dual-result mode a condition bit decides which of two ports carries the sum, and the other port is driven to a fixed pattern. Operands are unsigned. Each sum keeps only its low bits and the carry-out is lost. The block has no clock or state, and its outputs follow its inputs after the adder and multiplexer delay.

Top module: `shadd_share_unit`

## Requirements
- R1: With `dual_i`=0 and `sel_i`=2'b00, `r_o` equals (a_i+b_i) mod 2^W and `x_o` and `y_o` are all zeros.
- R2: With `dual_i`=0 and `sel_i`=2'b01, `r_o` equals (a_i+c_i) mod 2^W and `x_o` and `y_o` are all zeros.
- R3: With `dual_i`=0 and `sel_i` equal to 2'b10 or 2'b11, `r_o` equals (d_i+1) mod 2^W, so d_i=255 gives 0, and `x_o` and `y_o` are all zeros.
- R4: Every sum is truncated to W bits with the carry dropped. For example, 200+100 gives 44 and 255+255 gives 254.
- R5: With `dual_i`=1 and `cond_i`=1, `x_o` equals (a_i+b_i) mod 2^W, `y_o` is all zeros and `r_o` is all zeros.
- R6: With `dual_i`=1 and `cond_i`=0, `y_o` equals (c_i+d_i) mod 2^W, `x_o` is all ones and `r_o` is all zeros.
- R7: With `dual_i`=1, the value of `sel_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| c_i | input | W | Third operand |
| d_i | input | W | Fourth operand |
| sel_i | input | 2 | Sum select for single-result mode |
| dual_i | input | 1 | 1 selects dual-result mode |
| cond_i | input | 1 | Dual-mode condition: 1 routes a+b to x_o, 0 routes c+d to y_o |
| r_o | output | W | Single-mode result, zero in dual mode |
| x_o | output | W | Dual-mode first result, zero in single mode |
| y_o | output | W | Dual-mode second result, zero in single mode |

## Verification
The assertions are immediate checks on combinational values. They assume that every input holds a known 0 or 1 whenever they are evaluated, and they skip any evaluation in which an input is unknown. The bench keeps within this assumption because it drives all inputs to zero from time zero and then only ever drives complete, known vectors. Operand values include 0, 1, 128 and 255 as well as random values, so that each select code and each mode meets carry-out truncation at its extremes.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  typedef enum logic [1:0] {
    PICK_AB  = 2'b00,
    PICK_AC  = 2'b01,
    PICK_DI0 = 2'b10,
    PICK_DI1 = 2'b11
  } pick_e;

  typedef enum logic [1:0] {
    ROUTE_R   = 2'b00,
    ROUTE_X   = 2'b01,
    ROUTE_Y   = 2'b10
  } route_e;
endpackage

// File: rtl/shadd_opnd_sel.sv
module shadd_opnd_sel
  import shadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic [1:0]   sel_i,
  input  logic         dual_i,
  input  logic         cond_i,
  output logic [W-1:0] lhs_o,
  output logic [W-1:0] rhs_o,
  output route_e       route_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    lhs_o   = a_i;
    rhs_o   = b_i;
    route_o = ROUTE_R;
    if (dual_i) begin
      if (cond_i) begin
        lhs_o   = a_i;
        rhs_o   = b_i;
        route_o = ROUTE_X;
      end else begin
        lhs_o   = c_i;
        rhs_o   = d_i;
        route_o = ROUTE_Y;
      end
    end else begin
      unique case (pick_e'(sel_i))
        PICK_AB:  begin lhs_o = a_i; rhs_o = b_i; end
        PICK_AC:  begin lhs_o = a_i; rhs_o = c_i; end
        default:  begin lhs_o = d_i; rhs_o = ONE; end
      endcase
    end
  end
endmodule

// File: rtl/shadd_adder.sv
module shadd_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] sum_o
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W:0] full;
    full = {1'b0, p} + {1'b0, q};
    return full[W-1:0];
  endfunction

  assign sum_o = wrap_add(lhs_i, rhs_i);
endmodule

// File: rtl/shadd_out_steer.sv
module shadd_out_steer
  import shadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_i,
  input  route_e       route_i,
  output logic [W-1:0] r_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  always_comb begin
    r_o = ZERO;
    x_o = ZERO;
    y_o = ZERO;
    unique case (route_i)
      ROUTE_X: x_o = sum_i;
      ROUTE_Y: begin x_o = ONES; y_o = sum_i; end
      default: r_o = sum_i;
    endcase
  end
endmodule

// File: rtl/shadd_share_unit.sv
module shadd_share_unit
  import shadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic [1:0]   sel_i,
  input  logic         dual_i,
  input  logic         cond_i,
  output logic [W-1:0] r_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic [W-1:0] lhs_w;
  logic [W-1:0] rhs_w;
  logic [W-1:0] sum_w;
  route_e       route_w;

  shadd_opnd_sel #(.W(W)) u_sel (
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .sel_i(sel_i), .dual_i(dual_i), .cond_i(cond_i),
    .lhs_o(lhs_w), .rhs_o(rhs_w), .route_o(route_w)
  );

  shadd_adder #(.W(W)) u_add (
    .lhs_i(lhs_w), .rhs_i(rhs_w), .sum_o(sum_w)
  );

  shadd_out_steer #(.W(W)) u_steer (
    .sum_i(sum_w), .route_i(route_w),
    .r_o(r_o), .x_o(x_o), .y_o(y_o)
  );
endmodule

// File: rtl/shadd_share_unit_chk.sv
module shadd_share_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] c_i,
  input logic [W-1:0] d_i,
  input logic [1:0]   sel_i,
  input logic         dual_i,
  input logic         cond_i,
  input logic [W-1:0] r_o,
  input logic [W-1:0] x_o,
  input logic [W-1:0] y_o,
  input logic [W-1:0] lhs_w,
  input logic [W-1:0] rhs_w
);
  logic known;
  assign known = !$isunknown({a_i, b_i, c_i, d_i, sel_i, dual_i, cond_i});

  always_comb begin
    if (known) begin
      // R1
      r1_ab_sum_chk: assert (dual_i || sel_i != 2'b00 || r_o == W'(a_i + b_i));
      // R2
      r2_ac_operands_chk: assert (dual_i || sel_i != 2'b01 || (lhs_w == a_i && rhs_w == c_i));
      // R3
      r3_inc_operands_chk: assert (dual_i || !sel_i[1] || (lhs_w == d_i && rhs_w == W'(1)));
      // R1
      r1_single_quiet_chk: assert (dual_i || (x_o == '0 && y_o == '0));
      // R5
      r5_ysilent_chk: assert (!(dual_i && cond_i) || (y_o == '0 && r_o == '0));
      // R6
      r6_xones_chk: assert (!(dual_i && !cond_i) || (x_o == '1 && r_o == '0));
      // R4
      r4_wrap_chk: assert (!(dual_i && cond_i) || x_o == W'(a_i + b_i));
    end
  end
endmodule

bind shadd_share_unit shadd_share_unit_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
  .sel_i(sel_i), .dual_i(dual_i), .cond_i(cond_i),
  .r_o(r_o), .x_o(x_o), .y_o(y_o),
  .lhs_w(lhs_w), .rhs_w(rhs_w)
);

// File: tb/tb_shadd_share_unit.sv
`timescale 1ns/1ps
module tb_shadd_share_unit;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, c, d;
  logic [1:0]   sel;
  logic         dual, cond;
  logic [W-1:0] r, x, y;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    q_r[$], q_x[$], q_y[$];
  string q_tag[$];

  shadd_share_unit #(.W(W)) dut (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .sel_i(sel), .dual_i(dual), .cond_i(cond),
    .r_o(r), .x_o(x), .y_o(y)
  );

  task automatic compare(input string tag);
    int er, ex, ey;
    er = q_r.pop_front();
    ex = q_x.pop_front();
    ey = q_y.pop_front();
    checks++;
    if (int'(r) != er || int'(x) != ex || int'(y) != ey) begin
      errors++;
      $display("FAIL %s: got r=%0d x=%0d y=%0d expected r=%0d x=%0d y=%0d",
               tag, r, x, y, er, ex, ey);
    end
  endtask

  task automatic apply(input int ia, input int ib, input int ic, input int id,
                       input int isel, input bit idual, input bit icond, input string tag);
    int er, ex, ey;
    @(posedge clk);
    #1;
    a = W'(ia); b = W'(ib); c = W'(ic); d = W'(id);
    sel = 2'(isel); dual = idual; cond = icond;
    er = 0; ex = 0; ey = 0;
    if (!idual) begin
      if (isel == 0)      er = (ia + ib) % (MASK + 1);
      else if (isel == 1) er = (ia + ic) % (MASK + 1);
      else                er = (id + 1) % (MASK + 1);
    end else if (icond) begin
      ex = (ia + ib) % (MASK + 1);
    end else begin
      ex = MASK;
      ey = (ic + id) % (MASK + 1);
    end
    q_r.push_back(er); q_x.push_back(ex); q_y.push_back(ey);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string single_tag(input int isel);
    if (isel == 0) return "R1";
    if (isel == 1) return "R2";
    return "R3";
  endfunction

  initial begin
    a = '0; b = '0; c = '0; d = '0; sel = '0; dual = 1'b0; cond = 1'b0;
    repeat (3) @(posedge clk);
    // R1 reset state: zero inputs give zero outputs
    @(negedge clk);
    checks++;
    if (r != '0 || x != '0 || y != '0) begin
      errors++;
      $display("FAIL R1 reset: got r=%0d x=%0d y=%0d expected 0 0 0", r, x, y);
    end
    rst = 1'b0;

    // R3 boundary: d=255 wraps to 0, for both increment codes
    apply(0, 0, 0, 255, 2, 1'b0, 1'b0, "R3");
    apply(0, 0, 0, 255, 3, 1'b0, 1'b0, "R3");
    // R4 truncation
    apply(200, 100, 0, 0, 0, 1'b0, 1'b0, "R4");
    apply(255, 0, 255, 0, 1, 1'b0, 1'b0, "R4");
    apply(255, 255, 0, 0, 1, 1'b1, 1'b1, "R4");
    apply(0, 0, 255, 255, 0, 1'b1, 1'b0, "R4");

    // corner operand sweep over all select codes and both modes
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          int vals[4];
          vals = '{0, 1, 128, 255};
          apply(vals[i], vals[j], vals[j], vals[i], s, 1'b0, 1'b0, single_tag(s));
          apply(vals[i], vals[j], vals[i], vals[j], s, 1'b1, 1'b1, "R5");
          apply(vals[i], vals[j], vals[i], vals[j], s, 1'b1, 1'b0, "R6");
        end
      end
    end

    // R7: hold dual-mode operands, sweep the select code
    for (int k = 0; k < 8; k++) begin
      int ra, rb, rc, rd;
      ra = int'($urandom_range(255)); rb = int'($urandom_range(255));
      rc = int'($urandom_range(255)); rd = int'($urandom_range(255));
      for (int s = 0; s < 4; s++) begin
        apply(ra, rb, rc, rd, s, 1'b1, k[0], "R7");
      end
    end

    // random mix
    for (int k = 0; k < 300; k++) begin
      int ra, rb, rc, rd, rs;
      bit rdual, rcond;
      ra = int'($urandom_range(255)); rb = int'($urandom_range(255));
      rc = int'($urandom_range(255)); rd = int'($urandom_range(255));
      rs = int'($urandom_range(3));
      rdual = 1'($urandom_range(1)); rcond = 1'($urandom_range(1));
      apply(ra, rb, rc, rd, rs, rdual, rcond,
            rdual ? (rcond ? "R5" : "R6") : single_tag(rs));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule